// File: doc/BRIEF.md
# Timer Status Flag Bank with Access-Triggered Clearing

This block keeps the sticky status flags of a timer peripheral. There are NCH channel flags, one for each capture/compare channel. There are also single flags for:

- main counter overflow,
- pulse-accumulator A overflow,
- pulse-accumulator A input edge,
- pulse-accumulator B overflow,
- modulus counter reaching zero.

A one-cycle event strobe from the timer logic sets the matching flag. The flag then stays set until it is cleared.

Two clearing policies are available, and the `fast_clr_all` input picks between them.

- With `fast_clr_all` low, software clears flags by writing ones to the flag registers. Each written one clears the matching flag.
- With `fast_clr_all` high, flag-register writes are ignored. Instead, accessing the data register that belongs to a flag clears that flag as a side effect.

The register bus presents one access per cycle. Each access carries a valid strobe, a write strobe, a register code, a channel index and write data. Each channel's mode input says whether the channel is an output compare (1) or an input capture (0).

Top module: `tmr_flag_bank`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every flag output is 0.
- R2: An event strobe that is high in a cycle makes its flag read 1 from the next cycle on. The strobes are `ch_evt[i]`, `ovf_evt`, `pa_ovf_evt`, `pa_edge_evt`, `pb_ovf_evt` and `mz_evt`.
- R3: With `fast_clr_all`=0, a write clears flags for each bit of `acc_wdata` that is 1; bits that are 0 leave their flags unchanged. The register codes are:
  - code 5: bit i clears channel flag i;
  - code 6: bit 0 clears the counter overflow flag;
  - code 7: bit 0 clears the accumulator A edge flag and bit 1 clears the accumulator A overflow flag;
  - code 8: bit 0 clears the accumulator B overflow flag;
  - code 9: bit 0 clears the modulus-zero flag.
- R4: With `fast_clr_all`=0, reads and writes of the data registers (codes 0 to 4) clear no flag. A read of a flag register (codes 5 to 9) also clears no flag.
- R5: With `fast_clr_all`=1, a read of channel data (code 0, channel `acc_idx`) clears that channel's flag when `ch_is_oc[acc_idx]`=0. A write to the same channel clears nothing.
- R6: With `fast_clr_all`=1, a write of channel data (code 0) clears that channel's flag when `ch_is_oc[acc_idx]`=1. A read of the same channel clears nothing.
- R7: With `fast_clr_all`=1, any read or write of the counter register (code 1) clears the counter overflow flag.
- R8: With `fast_clr_all`=1, any access to the accumulator A count (code 2) clears both the A overflow flag and the A edge flag. Any access to the accumulator B count (code 3) clears only the B overflow flag.
- R9: With `fast_clr_all`=1, any access to the modulus counter register (code 4) clears the modulus-zero flag.
- R10: With `fast_clr_all`=1, a write of any data to the flag registers (codes 5 to 9) changes no flag.
- R11: When a flag's set event and its clear arrive in the same cycle, the flag reads 1 in the next cycle.
- R12: An access changes only the flags named in R3 to R10 for that access. Every other flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_clr_all | input | 1 | 1 selects access-triggered clearing, 0 selects write-one-to-clear |
| ch_is_oc | input | NCH | Per-channel mode, 1 = output compare, 0 = input capture |
| ch_evt | input | NCH | Channel event strobes |
| ovf_evt | input | 1 | Counter overflow strobe |
| pa_ovf_evt | input | 1 | Accumulator A overflow strobe |
| pa_edge_evt | input | 1 | Accumulator A input edge strobe |
| pb_ovf_evt | input | 1 | Accumulator B overflow strobe |
| mz_evt | input | 1 | Modulus counter zero strobe |
| acc_vld | input | 1 | Register access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 4 | Register code (0 to 9, see R3 to R10) |
| acc_idx | input | IW | Channel index for code 0 |
| acc_wdata | input | NCH | Write data |
| ch_flg | output | NCH | Channel flags |
| ovf_flg | output | 1 | Counter overflow flag |
| pa_ovf_flg | output | 1 | Accumulator A overflow flag |
| pa_edge_flg | output | 1 | Accumulator A edge flag |
| pb_ovf_flg | output | 1 | Accumulator B overflow flag |
| mz_flg | output | 1 | Modulus-zero flag |

## Verification
The assertions assume that at most one register access arrives per cycle, that `acc_sel` stays within codes 0 to 9, and that `acc_idx` is below NCH. The stimulus keeps to these limits. It sweeps every legal code, both directions, every channel index and two complementary mode patterns, and it issues exactly one access at a time. Before each access, every flag is raised by a burst of all events. Events are never raised during an access, except in the cases built to test R11. This keeps the clear-side properties free of interference from a set.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;

    typedef enum logic [3:0] {
        REG_CHDATA = 4'd0,
        REG_CNT    = 4'd1,
        REG_PA_CNT = 4'd2,
        REG_PB_CNT = 4'd3,
        REG_MOD    = 4'd4,
        REG_FL_CH  = 4'd5,
        REG_FL_OVF = 4'd6,
        REG_FL_PA  = 4'd7,
        REG_FL_PB  = 4'd8,
        REG_FL_MZ  = 4'd9
    } tmr_reg_e;

    typedef struct packed {
        logic ovf;
        logic pa_ovf;
        logic pa_edge;
        logic pb_ovf;
        logic mz;
    } misc_flags_t;

    localparam int MISC_W = $bits(misc_flags_t);

endpackage

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell #(
    parameter int W = 1
) (
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);
    // set has priority over clear so that no event is dropped
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            if (set_i[b])      nxt_o[b] = 1'b1;
            else if (clr_i[b]) nxt_o[b] = 1'b0;
            else               nxt_o[b] = cur_i[b];
        end
    end
endmodule

// File: rtl/tmr_clr_decode.sv
module tmr_clr_decode
    import tmr_flag_pkg::*;
#(
    parameter int NCH = 8,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              fast_i,
    input  logic              vld_i,
    input  logic              wr_i,
    input  logic [3:0]        sel_i,
    input  logic [IW-1:0]     idx_i,
    input  logic [NCH-1:0]    wdata_i,
    input  logic [NCH-1:0]    is_oc_i,
    output logic [NCH-1:0]    ch_clr_o,
    output misc_flags_t       misc_clr_o
);
    tmr_reg_e sel;
    logic     norm_wr;
    logic     fast_acc;

    assign sel      = tmr_reg_e'(sel_i);
    assign norm_wr  = vld_i && wr_i && !fast_i;
    assign fast_acc = vld_i && fast_i;

    // channel clears: one decoder slice per channel
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        logic dir_ok;
        assign hit    = fast_acc && (sel == REG_CHDATA) && (idx_i == IW'(i));
        assign dir_ok = is_oc_i[i] ? wr_i : !wr_i;
        assign ch_clr_o[i] = (hit && dir_ok) ||
                             (norm_wr && (sel == REG_FL_CH) && wdata_i[i]);
    end

    always_comb begin
        misc_clr_o = '0;
        if (fast_acc) begin
            unique case (sel)
                REG_CNT:    misc_clr_o.ovf = 1'b1;
                REG_PA_CNT: begin
                    misc_clr_o.pa_ovf  = 1'b1;
                    misc_clr_o.pa_edge = 1'b1;
                end
                REG_PB_CNT: misc_clr_o.pb_ovf = 1'b1;
                REG_MOD:    misc_clr_o.mz = 1'b1;
                default:    ;
            endcase
        end else if (norm_wr) begin
            unique case (sel)
                REG_FL_OVF: misc_clr_o.ovf = wdata_i[0];
                REG_FL_PA: begin
                    misc_clr_o.pa_edge = wdata_i[0];
                    misc_clr_o.pa_ovf  = (NCH > 1) ? wdata_i[NCH > 1 ? 1 : 0] : 1'b0;
                end
                REG_FL_PB:  misc_clr_o.pb_ovf = wdata_i[0];
                REG_FL_MZ:  misc_clr_o.mz = wdata_i[0];
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank
    import tmr_flag_pkg::*;
#(
    parameter int NCH = 8,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fast_clr_all,
    input  logic [NCH-1:0] ch_is_oc,
    input  logic [NCH-1:0] ch_evt,
    input  logic           ovf_evt,
    input  logic           pa_ovf_evt,
    input  logic           pa_edge_evt,
    input  logic           pb_ovf_evt,
    input  logic           mz_evt,
    input  logic           acc_vld,
    input  logic           acc_wr,
    input  logic [3:0]     acc_sel,
    input  logic [IW-1:0]  acc_idx,
    input  logic [NCH-1:0] acc_wdata,
    output logic [NCH-1:0] ch_flg,
    output logic           ovf_flg,
    output logic           pa_ovf_flg,
    output logic           pa_edge_flg,
    output logic           pb_ovf_flg,
    output logic           mz_flg
);
    typedef struct packed {
        logic [NCH-1:0] ch;
        misc_flags_t    misc;
    } flag_state_t;

    localparam int SW = $bits(flag_state_t);

    flag_state_t st_d, st_q;
    logic [NCH-1:0] ch_clr;
    misc_flags_t    misc_clr;
    misc_flags_t    misc_set;
    flag_state_t    set_all, clr_all;
    logic [SW-1:0]  nxt_vec;

    tmr_clr_decode #(.NCH(NCH)) u_dec (
        .fast_i     (fast_clr_all),
        .vld_i      (acc_vld),
        .wr_i       (acc_wr),
        .sel_i      (acc_sel),
        .idx_i      (acc_idx),
        .wdata_i    (acc_wdata),
        .is_oc_i    (ch_is_oc),
        .ch_clr_o   (ch_clr),
        .misc_clr_o (misc_clr)
    );

    always_comb begin
        misc_set.ovf     = ovf_evt;
        misc_set.pa_ovf  = pa_ovf_evt;
        misc_set.pa_edge = pa_edge_evt;
        misc_set.pb_ovf  = pb_ovf_evt;
        misc_set.mz      = mz_evt;
        set_all.ch   = ch_evt;
        set_all.misc = misc_set;
        clr_all.ch   = ch_clr;
        clr_all.misc = misc_clr;
    end

    tmr_flag_cell #(.W(SW)) u_cells (
        .set_i (set_all),
        .clr_i (clr_all),
        .cur_i (st_q),
        .nxt_o (nxt_vec)
    );

    always_comb begin
        st_d = flag_state_t'(nxt_vec);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ch_flg      = st_q.ch;
    assign ovf_flg     = st_q.misc.ovf;
    assign pa_ovf_flg  = st_q.misc.pa_ovf;
    assign pa_edge_flg = st_q.misc.pa_edge;
    assign pb_ovf_flg  = st_q.misc.pb_ovf;
    assign mz_flg      = st_q.misc.mz;
endmodule

// File: rtl/tmr_flag_bank_chk.sv
module tmr_flag_bank_chk #(
    parameter int NCH = 8,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           fast_clr_all,
    input logic [NCH-1:0] ch_evt,
    input logic           ovf_evt,
    input logic           pa_ovf_evt,
    input logic           pa_edge_evt,
    input logic           pb_ovf_evt,
    input logic           mz_evt,
    input logic           acc_vld,
    input logic           acc_wr,
    input logic [3:0]     acc_sel,
    input logic [IW-1:0]  acc_idx,
    input logic [NCH-1:0] ch_flg,
    input logic           ovf_flg,
    input logic           pa_ovf_flg,
    input logic           pa_edge_flg,
    input logic           pb_ovf_flg,
    input logic           mz_flg
);
    p_ch_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_evt) |=> ((ch_flg & $past(ch_evt)) == $past(ch_evt)));

    p_ovf_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flg);

    p_mz_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mz_flg) |-> $past(mz_evt));

    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && fast_clr_all && acc_sel == 4'd1 && !ovf_evt) |=> !ovf_flg);

    p_pa_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && fast_clr_all && acc_sel == 4'd2 && !pa_ovf_evt && !pa_edge_evt)
        |=> (!pa_ovf_flg && !pa_edge_flg));

    p_mod_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && fast_clr_all && acc_sel == 4'd4 && !mz_evt) |=> !mz_flg);

    p_fast_w1c_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_wr && fast_clr_all && acc_sel >= 4'd5)
        |=> ((ch_flg & $past(ch_flg)) == $past(ch_flg)));

    p_norm_data_noclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !fast_clr_all && acc_sel <= 4'd4)
        |=> (((ch_flg & $past(ch_flg)) == $past(ch_flg)) &&
             !($past(ovf_flg) && !ovf_flg) && !($past(mz_flg) && !mz_flg)));

    p_pb_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pb_ovf_flg) |-> $past(pb_ovf_evt));

    p_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_sel == 4'd0) |-> (int'(acc_idx) < NCH));
endmodule

bind tmr_flag_bank tmr_flag_bank_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fast_clr_all(fast_clr_all),
    .ch_evt      (ch_evt),
    .ovf_evt     (ovf_evt),
    .pa_ovf_evt  (pa_ovf_evt),
    .pa_edge_evt (pa_edge_evt),
    .pb_ovf_evt  (pb_ovf_evt),
    .mz_evt      (mz_evt),
    .acc_vld     (acc_vld),
    .acc_wr      (acc_wr),
    .acc_sel     (acc_sel),
    .acc_idx     (acc_idx),
    .ch_flg      (ch_flg),
    .ovf_flg     (ovf_flg),
    .pa_ovf_flg  (pa_ovf_flg),
    .pa_edge_flg (pa_edge_flg),
    .pb_ovf_flg  (pb_ovf_flg),
    .mz_flg      (mz_flg)
);

// File: tb/tmr_flag_bank_test.sv
module tmr_flag_bank_test;
    localparam int PERIOD = 10;
    localparam int NCH = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fast_clr_all = 1'b0;
    logic [NCH-1:0] ch_is_oc = '0;
    logic [NCH-1:0] ch_evt = '0;
    logic ovf_evt = 1'b0, pa_ovf_evt = 1'b0, pa_edge_evt = 1'b0;
    logic pb_ovf_evt = 1'b0, mz_evt = 1'b0;
    logic acc_vld = 1'b0, acc_wr = 1'b0;
    logic [3:0] acc_sel = '0;
    logic [IW-1:0] acc_idx = '0;
    logic [NCH-1:0] acc_wdata = '0;
    logic [NCH-1:0] ch_flg;
    logic ovf_flg, pa_ovf_flg, pa_edge_flg, pb_ovf_flg, mz_flg;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    tmr_flag_bank #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .fast_clr_all(fast_clr_all),
        .ch_is_oc(ch_is_oc), .ch_evt(ch_evt), .ovf_evt(ovf_evt),
        .pa_ovf_evt(pa_ovf_evt), .pa_edge_evt(pa_edge_evt),
        .pb_ovf_evt(pb_ovf_evt), .mz_evt(mz_evt),
        .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_sel(acc_sel),
        .acc_idx(acc_idx), .acc_wdata(acc_wdata),
        .ch_flg(ch_flg), .ovf_flg(ovf_flg), .pa_ovf_flg(pa_ovf_flg),
        .pa_edge_flg(pa_edge_flg), .pb_ovf_flg(pb_ovf_flg), .mz_flg(mz_flg)
    );

    // observed word: {mz, pb_ovf, pa_ovf, pa_edge, ovf, ch[7:0]}
    function automatic logic [12:0] obs();
        return {mz_flg, pb_ovf_flg, pa_ovf_flg, pa_edge_flg, ovf_flg, ch_flg};
    endfunction

    task automatic check(input string req, input logic [12:0] exp);
        total++;
        if (obs() !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, obs(), exp);
        end
    endtask

    task automatic raise_all();
        ch_evt = '1; ovf_evt = 1; pa_ovf_evt = 1; pa_edge_evt = 1;
        pb_ovf_evt = 1; mz_evt = 1;
        @(negedge clk);
        ch_evt = '0; ovf_evt = 0; pa_ovf_evt = 0; pa_edge_evt = 0;
        pb_ovf_evt = 0; mz_evt = 0;
    endtask

    task automatic access(input logic wr, input logic [3:0] sel,
                          input logic [IW-1:0] idx, input logic [NCH-1:0] wd);
        acc_vld = 1; acc_wr = wr; acc_sel = sel; acc_idx = idx; acc_wdata = wd;
        @(negedge clk);
        acc_vld = 0; acc_wr = 0;
    endtask

    function automatic logic [12:0] expect_after(input logic md, input logic wr,
            input int sel, input int idx, input logic [7:0] oc, input logic [7:0] wd);
        logic [12:0] e = 13'h1FFF;
        if (md) begin
            case (sel)
                0: if (wr == oc[idx]) e[idx] = 1'b0;
                1: e[8] = 1'b0;
                2: begin e[9] = 1'b0; e[10] = 1'b0; end
                3: e[11] = 1'b0;
                4: e[12] = 1'b0;
                default: ;
            endcase
        end else if (wr) begin
            case (sel)
                5: e[7:0] = e[7:0] & ~wd;
                6: if (wd[0]) e[8] = 1'b0;
                7: begin if (wd[0]) e[9] = 1'b0; if (wd[1]) e[10] = 1'b0; end
                8: if (wd[0]) e[11] = 1'b0;
                9: if (wd[0]) e[12] = 1'b0;
                default: ;
            endcase
        end
        return e;
    endfunction

    function automatic string tag_of(input logic md, input logic wr, input int sel);
        if (!md) return (sel >= 5 && wr) ? "R3" : "R4";
        case (sel)
            0: return wr ? "R6" : "R5";
            1: return "R7";
            2, 3: return "R8";
            4: return "R9";
            default: return "R10";
        endcase
    endfunction

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        check("R1", 13'h0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1", 13'h0);

        for (int md = 0; md < 2; md++) begin
            for (int pat = 0; pat < 2; pat++) begin
                for (int sel = 0; sel < 10; sel++) begin
                    for (int wr = 0; wr < 2; wr++) begin
                        for (int idx = 0; idx < NCH; idx++) begin
                            logic [7:0] oc;
                            logic [7:0] wd;
                            oc = pat ? 8'h39 : 8'hC6;
                            wd = 8'h5A ^ 8'(idx * 37) ^ {8{pat[0]}};
                            fast_clr_all = md[0];
                            ch_is_oc = oc;
                            raise_all();
                            check("R2", 13'h1FFF);
                            access(wr[0], 4'(sel), IW'(idx), wd);
                            // R12: untouched flags hold, compared as part of the word
                            check(tag_of(md[0], wr[0], sel),
                                  expect_after(md[0], wr[0], sel, idx, oc, wd));
                        end
                    end
                end
            end
        end

        // R11: set and fast clear in the same cycle
        fast_clr_all = 1;
        raise_all();
        ovf_evt = 1;
        access(1'b0, 4'd1, '0, '0);
        ovf_evt = 0;
        check("R11", 13'h1FFF);
        // R11: set and write-one-to-clear in the same cycle
        fast_clr_all = 0;
        raise_all();
        ch_evt = 8'h0F;
        access(1'b1, 4'd5, '0, 8'hFF);
        ch_evt = '0;
        check("R11", 13'h1F0F);
        // R2: single event from cleared state
        access(1'b1, 4'd9, '0, 8'h01);
        mz_evt = 1;
        @(negedge clk);
        mz_evt = 0;
        check("R2", 13'h1F0F);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule